// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the transfer engine of one DMA channel. Software loads a 16-bit start address, a 16-bit transfer count, an 8-bit page and an 8-bit high page. The engine then produces the 32-bit physical address for each transfer, advances the address, and counts the transfers down. When the last transfer has been taken it reports terminal count. A channel in byte mode addresses bytes. A channel in word mode addresses 16-bit words, so its address register is shifted one place to the left in the physical address.

Each transfer is a handshake on `step_valid`/`step_ready`. `step_ready` is high while the channel is enabled (not masked). A transfer is accepted on a rising clock edge where both signals are high. `step_valid` may be held high across cycles and has no effect while `step_ready` is low. While `step_ready` is high, `phys_addr` already shows the address of the transfer that the next accepted step will use.

Page carries follow a mode that software selects. Writing the low page register selects 16-bit wraparound. Writing the high page register selects full carry. Arbitration between channels and bus-cycle timing are handled outside this block.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is masked, `step_ready` is 0, `tc_pulse` is 0, `residue` is 0x0000 and `phys_addr` is 0x00000000.
- R2: In byte mode (`word_mode`=0), `phys_addr` is {high page[7:0], page[7:0], address[15:0]}.
- R3: In word mode (`word_mode`=1), `phys_addr` is {high page[7:0], page[7:1], address[15:0], 1'b0}. Page bit 0 does not affect the result.
- R4: Each accepted step adds 1 to the current address and subtracts 1 from the current count. `residue` shows the current count.
- R5: The count holds the number of transfers minus one. Loading N-1 gives exactly N transfers. `tc_pulse` is high for exactly one cycle, the cycle after the edge that accepts the step taken while the count is 0x0000. After a terminal count without auto-init, `residue`+1 wraps to 0x0000.
- R6: Until the high page has been written, an address wrap from 0xFFFF to 0x0000 leaves the page unchanged.
- R7: After the high page is written, an address wrap carries into {high page, page}. The carry adds 1 in byte mode and 2 in word mode.
- R8: Writing the low page turns off carry into the page. It stays off until the high page is written again.
- R9: At terminal count with `auto_init`=1, the current address, page, high page and count reload from their loaded values, and the channel stays enabled.
- R10: At terminal count with `auto_init`=0, the channel masks itself. `step_ready` goes low and `phys_addr` stops advancing.
- R11: A step offered while masked (`step_valid`=1, `step_ready`=0) changes neither `phys_addr` nor `residue`. `arm` unmasks the channel. `disarm` masks it, and `disarm` wins over `arm` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1 = word channel, 0 = byte channel |
| auto_init | input | 1 | Reload at terminal count instead of masking |
| ld_addr | input | 1 | Load the start address |
| addr_in | input | 16 | Start address value |
| ld_count | input | 1 | Load the transfer count (N-1) |
| count_in | input | 16 | Count value |
| ld_page | input | 1 | Load the low page; turns off page carry |
| page_in | input | 8 | Page value |
| ld_hipage | input | 1 | Load the high page; turns on page carry |
| hipage_in | input | 8 | High page value |
| arm | input | 1 | Clear the channel mask |
| disarm | input | 1 | Set the channel mask |
| step_valid | input | 1 | Transfer request |
| step_ready | output | 1 | Channel can accept a transfer |
| phys_addr | output | 32 | Physical address of the next transfer |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| residue | output | 16 | Current count readback |
| masked | output | 1 | Channel mask state |

## Verification
The assertions assume that no load strobe arrives in the same cycle as an accepted step. A load in that cycle takes priority over the step, so the step properties exclude it. The stimulus performs all loads before `arm` and offers steps only afterwards. The step-count property also assumes that `auto_init` is stable across a terminal count. The bench changes `auto_init` only while the channel is masked.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int PAGE_W = 8;
  localparam int PHYS_W = ADDR_W + 2 * PAGE_W;

  typedef struct packed {
    logic [PAGE_W-1:0] hi;
    logic [PAGE_W-1:0] lo;
  } page_pair_t;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic          ld_addr,
  input  logic [AW-1:0] addr_in,
  input  logic          ld_page,
  input  logic [PW-1:0] page_in,
  input  logic          ld_hipage,
  input  logic [PW-1:0] hipage_in,
  input  logic          adv,
  input  logic          reload,
  output logic [AW-1:0] cur_addr,
  output logic [PW-1:0] cur_page,
  output logic [PW-1:0] cur_hi,
  output logic          carry_en
);
  localparam int PP = 2 * PW;

  logic [AW-1:0] base_addr;
  logic [PW-1:0] base_page, base_hi;
  logic [AW:0]   addr_sum;
  logic [PP-1:0] pages_now, pages_next;
  logic          wrap;

  assign addr_sum   = {1'b0, cur_addr} + (AW+1)'(1);
  assign wrap       = addr_sum[AW];
  assign pages_now  = {cur_hi, cur_page};
  assign pages_next = pages_now + (word_mode ? PP'(2) : PP'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_page <= '0;
      base_hi   <= '0;
      cur_addr  <= '0;
      cur_page  <= '0;
      cur_hi    <= '0;
      carry_en  <= 1'b0;
    end else begin
      if (reload) begin
        cur_addr <= base_addr;
        cur_page <= base_page;
        cur_hi   <= base_hi;
      end else if (adv) begin
        cur_addr <= addr_sum[AW-1:0];
        if (wrap && carry_en) begin
          cur_hi   <= pages_next[PP-1:PW];
          cur_page <= pages_next[PW-1:0];
        end
      end
      if (ld_addr) begin
        base_addr <= addr_in;
        cur_addr  <= addr_in;
      end
      if (ld_page) begin
        base_page <= page_in;
        cur_page  <= page_in;
        carry_en  <= 1'b0;
      end
      if (ld_hipage) begin
        base_hi  <= hipage_in;
        cur_hi   <= hipage_in;
        carry_en <= 1'b1;
      end
    end
  end

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload && !carry_en && cur_addr == '1 && !ld_page && !ld_hipage && !ld_addr)
    |=> (cur_page == $past(cur_page) && cur_hi == $past(cur_hi) && cur_addr == '0));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload && !ld_addr) |=> cur_addr == $past(cur_addr) + AW'(1));
endmodule

// File: rtl/dma_cnt_ctr.sv
module dma_cnt_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_count,
  input  logic [CW-1:0] count_in,
  input  logic          adv,
  input  logic          auto_init,
  output logic [CW-1:0] cur_cnt,
  output logic          last,
  output logic          tc_q
);
  logic [CW-1:0] base_cnt;

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= adv && last;
      if (ld_count) begin
        base_cnt <= count_in;
        cur_cnt  <= count_in;
      end else if (adv) begin
        cur_cnt <= (last && auto_init) ? base_cnt : cur_cnt - CW'(1);
      end
    end
  end

  // R5
  tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> $past(adv && cur_cnt == '0));

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld_count && !(last && auto_init)) |=> cur_cnt == $past(cur_cnt) - CW'(1));

  // R5
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q || $past(adv && cur_cnt == '0));
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic                 word_mode,
  input  logic [AW-1:0]        cur_addr,
  input  logic [PW-1:0]        cur_page,
  input  logic [PW-1:0]        cur_hi,
  output logic [AW+2*PW-1:0]   phys
);
  logic [AW+2*PW-1:0] byte_map, word_map;

  assign byte_map = {cur_hi, cur_page, cur_addr};
  assign word_map = {cur_hi, cur_page[PW-1:1], cur_addr, 1'b0};
  assign phys     = word_mode ? word_map : byte_map;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int PW = PAGE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_mode,
  input  logic                auto_init,
  input  logic                ld_addr,
  input  logic [AW-1:0]       addr_in,
  input  logic                ld_count,
  input  logic [CW-1:0]       count_in,
  input  logic                ld_page,
  input  logic [PW-1:0]       page_in,
  input  logic                ld_hipage,
  input  logic [PW-1:0]       hipage_in,
  input  logic                arm,
  input  logic                disarm,
  input  logic                step_valid,
  output logic                step_ready,
  output logic [AW+2*PW-1:0]  phys_addr,
  output logic                tc_pulse,
  output logic [CW-1:0]       residue,
  output logic                masked
);
  logic          mask_q, fire, last, reload, carry_en;
  logic [AW-1:0] cur_addr;
  logic [PW-1:0] cur_page, cur_hi;
  page_pair_t    pg_view;

  assign step_ready = !mask_q;
  assign fire       = step_valid && step_ready;
  assign reload     = fire && last && auto_init;
  assign masked     = mask_q;
  assign pg_view    = '{hi: cur_hi, lo: cur_page};

  always_ff @(posedge clk) begin
    if (!rst_n)                             mask_q <= 1'b1;
    else if (disarm || (fire && last && !auto_init)) mask_q <= 1'b1;
    else if (arm)                           mask_q <= 1'b0;
  end

  dma_addr_ctr #(.AW(AW), .PW(PW)) u_addr (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .ld_addr(ld_addr), .addr_in(addr_in),
    .ld_page(ld_page), .page_in(page_in),
    .ld_hipage(ld_hipage), .hipage_in(hipage_in),
    .adv(fire), .reload(reload),
    .cur_addr(cur_addr), .cur_page(cur_page), .cur_hi(cur_hi),
    .carry_en(carry_en)
  );

  dma_cnt_ctr #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_count(ld_count), .count_in(count_in),
    .adv(fire), .auto_init(auto_init),
    .cur_cnt(residue), .last(last), .tc_q(tc_pulse)
  );

  dma_phys_map #(.AW(AW), .PW(PW)) u_map (
    .word_mode(word_mode), .cur_addr(cur_addr),
    .cur_page(pg_view.lo), .cur_hi(pg_view.hi), .phys(phys_addr)
  );

  // R10
  stop_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && !auto_init) |=> masked);

  // R9
  auto_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && auto_init && !disarm) |=> !masked);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && !ld_addr && !ld_count && !ld_page && !ld_hipage)
    |=> ($stable(residue) && $stable(cur_addr)));
endmodule

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0, auto_init = 1'b0;
  logic        ld_addr = 1'b0, ld_count = 1'b0, ld_page = 1'b0, ld_hipage = 1'b0;
  logic [15:0] addr_in = '0, count_in = '0;
  logic [7:0]  page_in = '0, hipage_in = '0;
  logic        arm = 1'b0, disarm = 1'b0, step_valid = 1'b0;
  logic        step_ready, tc_pulse, masked;
  logic [31:0] phys_addr;
  logic [15:0] residue;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dma_chan_engine i_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .auto_init(auto_init),
    .ld_addr(ld_addr), .addr_in(addr_in), .ld_count(ld_count), .count_in(count_in),
    .ld_page(ld_page), .page_in(page_in), .ld_hipage(ld_hipage), .hipage_in(hipage_in),
    .arm(arm), .disarm(disarm), .step_valid(step_valid), .step_ready(step_ready),
    .phys_addr(phys_addr), .tc_pulse(tc_pulse), .residue(residue), .masked(masked)
  );

  // vector: {word, page, hipage, addr, expected phys}
  localparam logic [64:0] VEC [6] = '{
    {1'b0, 8'h12, 8'h00, 16'h3456, 32'h0012_3456},
    {1'b0, 8'hFF, 8'hAB, 16'hFFFF, 32'hABFF_FFFF},
    {1'b1, 8'h13, 8'h00, 16'h8001, 32'h0013_0002},
    {1'b1, 8'h00, 8'h7F, 16'hFFFF, 32'h7F01_FFFE},
    {1'b0, 8'h00, 8'h00, 16'h0000, 32'h0000_0000},
    {1'b1, 8'h01, 8'h00, 16'h0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_addr(input logic [15:0] v);
    @(negedge clk); addr_in = v; ld_addr = 1'b1;
    @(negedge clk); ld_addr = 1'b0;
  endtask
  task automatic load_cnt(input logic [15:0] v);
    @(negedge clk); count_in = v; ld_count = 1'b1;
    @(negedge clk); ld_count = 1'b0;
  endtask
  task automatic load_page(input logic [7:0] v);
    @(negedge clk); page_in = v; ld_page = 1'b1;
    @(negedge clk); ld_page = 1'b0;
  endtask
  task automatic load_hi(input logic [7:0] v);
    @(negedge clk); hipage_in = v; ld_hipage = 1'b1;
    @(negedge clk); ld_hipage = 1'b0;
  endtask
  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask
  task automatic step();
    @(negedge clk); step_valid = 1'b1;
    @(negedge clk); step_valid = 1'b0;
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 masked", {31'd0, masked}, 32'd1);
    chk("R1 ready", {31'd0, step_ready}, 32'd0);
    chk("R1 tc", {31'd0, tc_pulse}, 32'd0);
    chk("R1 residue", {16'd0, residue}, 32'd0);
    chk("R1 phys", phys_addr, 32'd0);

    // R2 / R3 address map table
    for (int i = 0; i < 6; i++) begin
      word_mode = VEC[i][64];
      load_page(VEC[i][63:56]);
      load_addr(VEC[i][47:32]);
      load_hi(VEC[i][55:48]);
      @(negedge clk);
      chk(VEC[i][64] ? "R3 word map" : "R2 byte map", phys_addr, VEC[i][31:0]);
    end

    // R4 R5 R10: byte, three transfers, no auto-init
    word_mode = 1'b0; auto_init = 1'b0;
    load_hi(8'h00); load_page(8'h05); load_addr(16'h1000); load_cnt(16'h0002);
    do_arm();
    chk("R11 arm", {31'd0, step_ready}, 32'd1);
    step();
    chk("R4 addr step1", phys_addr, 32'h0005_1001);
    chk("R4 residue step1", {16'd0, residue}, 32'h1);
    step();
    chk("R4 residue step2", {16'd0, residue}, 32'h0);
    chk("R5 no early tc", {31'd0, tc_pulse}, 32'd0);
    @(negedge clk); step_valid = 1'b1;
    @(negedge clk); step_valid = 1'b0;
    chk("R5 tc pulse", {31'd0, tc_pulse}, 32'd1);
    chk("R5 residue+1", {16'd0, residue + 16'd1}, 32'd0);
    chk("R10 masked", {31'd0, step_ready}, 32'd0);
    @(negedge clk);
    chk("R5 tc one cycle", {31'd0, tc_pulse}, 32'd0);
    // R11 step offered while masked
    @(negedge clk); step_valid = 1'b1;
    repeat (2) @(negedge clk);
    step_valid = 1'b0;
    chk("R10 addr frozen", phys_addr, 32'h0005_1003);
    chk("R11 residue frozen", {16'd0, residue}, 32'h0000_FFFF);

    // R11 disarm wins over arm
    @(negedge clk); arm = 1'b1; disarm = 1'b1;
    @(negedge clk); arm = 1'b0; disarm = 1'b0;
    chk("R11 disarm priority", {31'd0, masked}, 32'd1);

    // R6: no carry before high page write
    load_page(8'h22); load_addr(16'hFFFF); load_cnt(16'h0005);
    do_arm(); step();
    chk("R6 page held", phys_addr, 32'h0022_0000);

    // R7 byte carry
    @(negedge clk); disarm = 1'b1; @(negedge clk); disarm = 1'b0;
    load_page(8'h22); load_addr(16'hFFFF); load_hi(8'h00);
    do_arm(); step();
    chk("R7 byte carry", phys_addr, 32'h0023_0000);

    // R7 word carry
    @(negedge clk); disarm = 1'b1; @(negedge clk); disarm = 1'b0;
    word_mode = 1'b1;
    load_page(8'h22); load_addr(16'hFFFF); load_hi(8'h01);
    chk("R7 word before", phys_addr, 32'h0123_FFFE);
    do_arm(); step();
    chk("R7 word carry", phys_addr, 32'h0124_0000);

    // R8 page write disables carry again
    @(negedge clk); disarm = 1'b1; @(negedge clk); disarm = 1'b0;
    word_mode = 1'b0;
    load_page(8'h30); load_addr(16'hFFFF);
    do_arm(); step();
    chk("R8 carry off", phys_addr, 32'h0130_0000);

    // R9 auto-init reload
    @(negedge clk); disarm = 1'b1; @(negedge clk); disarm = 1'b0;
    auto_init = 1'b1;
    load_hi(8'h00); load_page(8'h00); load_addr(16'h0100); load_cnt(16'h0001);
    do_arm(); step();
    chk("R9 mid", phys_addr, 32'h0000_0101);
    step();
    chk("R9 tc", {31'd0, tc_pulse}, 32'd1);
    chk("R9 addr reload", phys_addr, 32'h0000_0100);
    chk("R9 count reload", {16'd0, residue}, 32'h1);
    chk("R9 still enabled", {31'd0, step_ready}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule